// File: doc/BRIEF.md
# Digit-Serial Multiplier for the 89-Bit Binary Field

This block multiplies two elements of GF(2^89) and returns the reduced product. Elements use polynomial basis: bit i of a word is the coefficient of u^i. The field polynomial is the trinomial u^89 + u^38 + 1. The block is the base-field engine of a larger elliptic-curve datapath. In that datapath a GF(2^178) value is held as a pair of 89-bit halves, and every extension-field product is built from several calls to this unit.

A one-cycle start strobe captures both operands. The multiplier operand is then consumed four bits per clock, most significant digit first, by Horner's rule: the accumulator is multiplied by u^4, the digit times the multiplicand is added, and the overflow is folded back at once through u^89 = u^38 + 1. After 23 digit steps a one-cycle done strobe marks the result. The result stays on the output until the next accepted start. When the unit is neither starting, working, flagging completion nor in reset, its internal clock is gated off.

Top module: `gf89_mul`

## Requirements
- R1: When `done_o` is high, `prod_o` equals `a_i`·`b_i` mod (u^89 + u^38 + 1). Both operands are taken as sampled at the accepted start. Bit i of each word is the coefficient of u^i.
- R2: `done_o` is high for exactly one cycle. It rises 23 rising edges after the edge that accepted the start.
- R3: `busy_o` is high from the edge that accepts a start until the edge that raises `done_o`. A start strobe while `busy_o` is high is ignored, and it leaves both the timing and the result unchanged.
- R4: Changes on `a_i` and `b_i` after the accepting edge have no effect on the product in progress.
- R5: After `done_o`, `prod_o` keeps its value until the next accepted start.
- R6: A start presented in the same cycle as `done_o` is accepted. The new product then follows with the same 23-cycle latency.
- R7: While `rst_n` is low at a rising edge, `busy_o`, `done_o` and `prod_o` are cleared to zero. This also aborts a product in progress.
- R8: While idle with no start, the internal clock is gated off. `busy_o`, `done_o` and `prod_o` do not move, whatever `a_i` and `b_i` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe; captures operands when idle |
| a_i | input | 89 | Multiplicand |
| b_i | input | 89 | Multiplier, consumed four bits per cycle from the top |
| busy_o | output | 1 | A product is in progress |
| done_o | output | 1 | One-cycle strobe: product valid |
| prod_o | output | 89 | Reduced product |

## Verification
Two things can land in one cycle: the completion strobe of one product and the acceptance of the next start. The bench provokes this by raising a new start in the same cycle in which it sees `done_o`. It then judges both results: the first product must be correct in the done cycle, and the second must finish exactly 23 cycles later with its own correct value. A second overlap is also covered: start strobes and changing operands injected while busy must leave both the latency and the first result untouched.

// File: rtl/gf89_pkg.sv
// Package: shared sizing for the GF(2^89) digit-serial multiplier.
// Assumes the trinomial tap plus the digit width stays below the field
// width, so a single fold clears every overflow bit.
package gf89_pkg;
    localparam int FIELD_W  = 89;   // degree of the field polynomial
    localparam int TAP_POS  = 38;   // middle term of the trinomial
    localparam int DIGIT_W  = 4;    // multiplier bits per cycle (radix 16)
endpackage

// File: rtl/gf89_clk_gate.sv
// Module: clock gate for the multiplier core.
// With GATE_EN set, a latch that is transparent while the clock is low holds
// the enable, so the gated clock has no glitches. With GATE_EN clear, the
// clock passes through unchanged.
module gf89_clk_gate #(
    parameter bit GATE_EN = 1'b1
) (
    input  logic clk_i,
    input  logic en_i,
    output logic gclk_o
);
    generate
        if (GATE_EN) begin : g_latch
            logic en_lat;
            // Latch the enable during the low phase of the clock.
            always_latch begin
                if (!clk_i) en_lat = en_i;
            end
            assign gclk_o = clk_i & en_lat;
        end else begin : g_pass
            assign gclk_o = clk_i;
        end
    endgenerate
endmodule

// File: rtl/gf89_digit_step.sv
// Module: one combinational Horner step, acc*u^D + digit*a, reduced.
// The shifted accumulator and the partial products together span at most
// W+D bits. Each overflow bit u^(W+k) is folded back as u^k + u^(TAP+k).
// This needs TAP+D <= W.
module gf89_digit_step #(
    parameter int W   = 89,
    parameter int D   = 4,
    parameter int TAP = 38
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] a_i,
    input  logic [D-1:0] dig_i,
    output logic [W-1:0] acc_o
);
    localparam int WIDE = W + D;

    logic [WIDE-1:0] pp [D];
    logic [WIDE-1:0] wide_sum;

    generate
        for (genvar j = 0; j < D; j++) begin : g_pp
            // Partial product for digit bit j: a shifted by j when the bit is set.
            assign pp[j] = dig_i[j] ? (WIDE'(a_i) << j) : '0;
        end
    endgenerate

    // Sum the shifted accumulator with every partial product.
    always_comb begin
        wide_sum = {acc_i, {D{1'b0}}};
        for (int j = 0; j < D; j++) wide_sum = wide_sum ^ pp[j];
    end

    // Fold the D overflow bits through the two trinomial taps.
    always_comb begin
        acc_o = wide_sum[W-1:0];
        for (int k = 0; k < D; k++) begin
            acc_o[k]       = acc_o[k]       ^ wide_sum[W+k];
            acc_o[TAP + k] = acc_o[TAP + k] ^ wide_sum[W+k];
        end
    end
endmodule

// File: rtl/gf89_mul_ctrl.sv
// Module: sequencer for the digit-serial multiplier.
// Accepts a start only when idle. It then counts NUM_STEPS digit steps and
// raises a one-cycle done on the last one. Runs on the gated clock, so the
// top must keep the clock enabled while busy and while done is high.
module gf89_mul_ctrl #(
    parameter int NUM_STEPS = 23
) (
    input  logic gclk_i,
    input  logic rst_n,
    input  logic start_i,
    output logic accept_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(NUM_STEPS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_STEPS - 1);

    logic [CNT_W-1:0] cnt_q;

    assign accept_o = start_i & ~busy_o;

    // Step counter, busy flag and done strobe.
    always_ff @(posedge gclk_i) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_o <= 1'b0;
            done_o <= 1'b0;
        end else if (accept_o) begin
            cnt_q  <= '0;
            busy_o <= 1'b1;
            done_o <= 1'b0;
        end else if (busy_o) begin
            cnt_q  <= cnt_q + 1'b1;
            busy_o <= (cnt_q != LAST);
            done_o <= (cnt_q == LAST);
        end else begin
            done_o <= 1'b0;
        end
    end

    // R2: completion is a single-cycle strobe.
    p_done_pulse_r2: assert property (@(posedge gclk_i) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: the step count never passes the last digit.
    p_cnt_range_r2: assert property (@(posedge gclk_i) disable iff (!rst_n)
        busy_o |-> (cnt_q <= LAST));

    // R3: a start during a run does not cut it short.
    p_busy_hold_r3: assert property (@(posedge gclk_i) disable iff (!rst_n)
        (busy_o && cnt_q != LAST) |=> busy_o);
endmodule

// File: rtl/gf89_mul.sv
// Module: GF(2^89) radix-16 multiplier, top level.
// Captures the operands on an accepted start. The multiplier is zero-padded
// to a whole number of digits and shifted out top digit first; each digit
// goes through one Horner step per cycle. The accumulator is the product
// output and holds until the next accepted start. Everything runs on a clock
// that is enabled only by reset, start, busy or done.
module gf89_mul
    import gf89_pkg::*;
#(
    parameter int W       = FIELD_W,
    parameter int D       = DIGIT_W,
    parameter int TAP     = TAP_POS,
    parameter bit GATE_EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] prod_o
);
    localparam int NUM_STEPS = (W + D - 1) / D;
    localparam int PAD_W     = NUM_STEPS * D;

    logic             gclk;
    logic             clk_en;
    logic             accept;
    logic [W-1:0]     a_q;
    logic [PAD_W-1:0] b_q;
    logic [W-1:0]     acc_q;
    logic [W-1:0]     acc_next;

    // Keep the core clocked only while there is something to do.
    assign clk_en = ~rst_n | start_i | busy_o | done_o;

    gf89_clk_gate #(.GATE_EN(GATE_EN)) u_gate (
        .clk_i  (clk),
        .en_i   (clk_en),
        .gclk_o (gclk)
    );

    gf89_mul_ctrl #(.NUM_STEPS(NUM_STEPS)) u_ctrl (
        .gclk_i   (gclk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    gf89_digit_step #(.W(W), .D(D), .TAP(TAP)) u_step (
        .acc_i (acc_q),
        .a_i   (a_q),
        .dig_i (b_q[PAD_W-1 -: D]),
        .acc_o (acc_next)
    );

    // Operand capture, multiplier shift-out and accumulator update.
    always_ff @(posedge gclk) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            acc_q <= '0;
        end else if (accept) begin
            a_q   <= a_i;
            b_q   <= PAD_W'(b_i);
            acc_q <= '0;
        end else if (busy_o) begin
            acc_q <= acc_next;
            b_q   <= b_q << D;
        end
    end

    assign prod_o = acc_q;

    // R6: an idle start, including one in the done cycle, begins a run.
    p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R5/R8: with no run and no start, the result and flags hold still.
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(prod_o) && !busy_o));

    // R7: reset clears the outputs.
    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && prod_o == '0));
endmodule

// File: tb/gf89_mul_tb.sv
module gf89_mul_tb;
    localparam int W = 89;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [W-1:0] prod_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    gf89_mul u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .a_i(a_i), .b_i(b_i),
        .busy_o(busy_o), .done_o(done_o), .prod_o(prod_o)
    );

    always #2 clk = ~clk;

    localparam logic [W-1:0] VA [0:7] = '{
        89'h0, 89'h1, 89'd1 << 88, {W{1'b1}},
        89'h123456789ABCDEF0123456, {W{1'b1}}, 89'd1 << 88, 89'h0F0F0F0F0F0F0F0F0F0F0F
    };
    localparam logic [W-1:0] VB [0:7] = '{
        89'h5A5A5A5A5A5A5A5A5A5A5A, 89'hFEDCBA9876543210FEDCBA, 89'd2, {W{1'b1}},
        89'h1, 89'd1 << 88, 89'd1 << 88, 89'h8000000000000000000001
    };

    // Bitwise Horner model: one multiplier bit per step, reduced each step.
    function automatic logic [W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] r = '0;
        for (int i = W - 1; i >= 0; i--) begin
            logic top = r[W-1];
            r = {r[W-2:0], 1'b0};
            if (top) begin
                r[0]  = ~r[0];
                r[38] = ~r[38];
            end
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    function automatic logic [W-1:0] rnd89();
        return W'({$urandom, $urandom, $urandom});
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge. Starts a product and walks to its done cycle.
    // With disturb set, the operands change and start pulses during the run.
    task automatic do_mul(input logic [W-1:0] a, input logic [W-1:0] b, input bit disturb,
                          input string tag);
        logic [W-1:0] exp = ref_mul(a, b);
        a_i = a; b_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk({tag, " R3 busy after start"}, W'(busy_o), W'(1));
        for (int k = 1; k <= 23; k++) begin
            if (disturb) begin
                a_i = rnd89(); b_i = rnd89(); start_i = (k % 3 == 1);
            end
            @(negedge clk);
            start_i = 1'b0;
            if (k < 23) begin
                if (done_o !== 1'b0 || busy_o !== 1'b1) begin
                    chk({tag, " R2 done early / R3 busy"}, W'({done_o, busy_o}), W'(2'b01));
                end
            end else begin
                chk({tag, " R2 done at 23"}, W'(done_o), W'(1));
                chk({tag, " R3 busy low at done"}, W'(busy_o), W'(0));
                chk({tag, disturb ? " R4 product" : " R1 product"}, prod_o, exp);
            end
        end
    endtask

    // Idle cycles with scrambled inputs: the result must hold, done must drop.
    task automatic idle_hold(input int n, input string tag);
        logic [W-1:0] held = prod_o;
        for (int k = 0; k < n; k++) begin
            a_i = rnd89(); b_i = rnd89();
            @(negedge clk);
            chk({tag, " R5 R8 product held"}, prod_o, held);
            chk({tag, " R8 flags idle"}, W'({done_o, busy_o}), W'(0));
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R7 reset prod", prod_o, '0);
        chk("R7 reset flags", W'({done_o, busy_o}), W'(0));

        // Vector table, each followed by idle hold checks.
        for (int v = 0; v < 8; v++) begin
            do_mul(VA[v], VB[v], 1'b0, $sformatf("vec%0d", v));
            idle_hold(2, $sformatf("vec%0d", v));
        end

        // Hand-derived corner: u^88 * u = u^89 = u^38 + 1.
        do_mul(89'd1 << 88, 89'd2, 1'b0, "wrap");
        chk("R1 u^89 fold", prod_o, (89'd1 << 38) | 89'd1);
        idle_hold(1, "wrap");

        // Random operands.
        for (int r = 0; r < 20; r++) begin
            do_mul(rnd89(), rnd89(), 1'b0, $sformatf("rnd%0d", r));
            idle_hold(1, "rnd");
        end

        // Operand changes and start pulses while busy.
        for (int r = 0; r < 4; r++) begin
            do_mul(rnd89(), rnd89(), 1'b1, "dist");
            idle_hold(1, "dist");
        end

        // Back-to-back: new start in the done cycle.
        do_mul(rnd89(), rnd89(), 1'b0, "b2b0");
        do_mul(rnd89(), rnd89(), 1'b0, "R6 b2b1");
        do_mul(VA[4], VB[0], 1'b0, "R6 b2b2");
        idle_hold(1, "b2b");

        // Reset in the middle of a run aborts it.
        a_i = rnd89(); b_i = rnd89(); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R7 mid-run reset prod", prod_o, '0);
        chk("R7 mid-run reset flags", W'({done_o, busy_o}), W'(0));
        idle_hold(3, "post-reset");
        do_mul({W{1'b1}}, 89'h1, 1'b0, "R7 after reset");

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule